// File: doc/BRIEF.md
# Bidirectional Bus Address Translation Unit

This block maps word-aligned addresses between a 32-bit local system space and an external interconnect that separates memory, I/O and configuration address spaces. Requests leaving the chip arrive as an offset inside a fixed 256 MiB local window. They are matched against a set of outbound regions and leave as a typed external address. Requests arriving from the interconnect carry a space type and a 64-bit address. They are matched against a set of inbound regions and leave as a 32-bit local address.

Every region holds an enable flag, a space type, an inclusive base and limit, and a target. A hit returns target plus the distance from base. When several regions hit, the lowest-numbered one wins. Configuration requests from the interconnect never use a region. They are flagged for the block's own configuration registers. A 32-bit register write port programs every region field. Each lookup is registered, so a result appears one cycle after its request.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, both result-valid outputs are low and every region is disabled, so any lookup made before programming reports a miss.
- R2: A result-valid output is high in exactly the cycle after the cycle its request-valid input is high, and low otherwise.
- R3: A region hits when it is enabled, its type equals the request type (0 memory, 1 I/O, 2 configuration) and base <= address <= limit, both bounds inclusive. The result is target + (address - base), and the region index is reported.
- R4: When more than one region hits, the lowest-numbered region supplies the result.
- R5: When no region hits (disabled, wrong type or out of range), the miss flag is high and the result address is zero.
- R6: A memory-type outbound hit gives the full 64-bit sum when the region's wide bit (control bit 3) is set, and only the low 32 bits otherwise. An I/O-type outbound hit always gives only the low 32 bits.
- R7: A configuration-type outbound hit gives a 28-bit address, split into bus [27:20], device [19:15], function [14:12] and register offset [11:0] on separate outputs. These outputs are zero for other results.
- R8: An inbound memory or I/O lookup compares the full 64-bit external address and returns a 32-bit local address.
- R9: An inbound configuration-type request sets the configuration flag, clears the miss flag and returns address zero, even when an enabled region is programmed with configuration type and covers the address.
- R10: The two lowest address bits of any request are treated as zero.
- R11: A register write (write enable high) selects the direction (0 outbound, 1 inbound), the region index and a field: 0 control (bit 0 enable, bits 2:1 type, bit 3 wide), 1/2 base low/high word, 3/4 limit low/high word, 5/6 target low/high word. The new value applies to lookups that start in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Region field write strobe |
| reg_dir | input | 1 | Table select: 0 outbound, 1 inbound |
| reg_idx | input | 2 | Region index |
| reg_field | input | 3 | Field select |
| reg_wdata | input | 32 | Write data |
| ob_req_valid | input | 1 | Outbound request valid |
| ob_req_space | input | 2 | Outbound target space type |
| ob_req_offset | input | 28 | Offset inside the local window |
| ob_rsp_valid | output | 1 | Outbound result valid |
| ob_rsp_miss | output | 1 | No outbound region hit |
| ob_rsp_region | output | 2 | Winning outbound region |
| ob_rsp_space | output | 2 | Space type of the result |
| ob_rsp_addr | output | 64 | Translated external address |
| ob_cfg_bus | output | 8 | Configuration bus number |
| ob_cfg_dev | output | 5 | Configuration device number |
| ob_cfg_func | output | 3 | Configuration function number |
| ob_cfg_reg | output | 12 | Configuration register offset |
| ib_req_valid | input | 1 | Inbound request valid |
| ib_req_space | input | 2 | Inbound request space type |
| ib_req_addr | input | 64 | External address |
| ib_rsp_valid | output | 1 | Inbound result valid |
| ib_rsp_miss | output | 1 | No inbound region hit |
| ib_rsp_cfg | output | 1 | Routed to internal configuration registers |
| ib_rsp_region | output | 2 | Winning inbound region |
| ib_rsp_addr | output | 32 | Translated local address |

## Verification
The hardest case to reach is a tie between regions. It needs two enabled regions of the same type whose ranges overlap, and a probe inside the shared part. The stimulus programs outbound regions 0 and 1 to overlap, probes the overlap, and then disables region 0 so the same probe lands in region 1. The inbound bypass is tested by enabling a configuration-type inbound region that covers the probed address. A configuration request must still bypass it.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;

   localparam int unsigned REG_AW = 64;

   typedef enum logic [1:0] {
      SP_MEM  = 2'd0,
      SP_IO   = 2'd1,
      SP_CFG  = 2'd2,
      SP_RSVD = 2'd3
   } space_t;

   typedef enum logic [2:0] {
      FLD_CTRL    = 3'd0,
      FLD_BASE_LO = 3'd1,
      FLD_BASE_HI = 3'd2,
      FLD_LIM_LO  = 3'd3,
      FLD_LIM_HI  = 3'd4,
      FLD_TGT_LO  = 3'd5,
      FLD_TGT_HI  = 3'd6
   } field_t;

   typedef struct packed {
      logic              en;
      space_t            sp;
      logic              wide;
      logic [REG_AW-1:0] base;
      logic [REG_AW-1:0] limit;
      logic [REG_AW-1:0] target;
   } region_t;

   function automatic logic [REG_AW-1:0] put_word(input logic [REG_AW-1:0] old,
                                                  input logic              hi,
                                                  input logic [31:0]       d);
      logic [REG_AW-1:0] r;
      r = old;
      if (hi) r[63:32] = d;
      else    r[31:0]  = d;
      return r;
   endfunction

endpackage

// File: rtl/xlate_region_file.sv
module xlate_region_file
   import addr_xlate_pkg::*;
#(
   parameter  int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     idx,
   input  logic [2:0]        field,
   input  logic [31:0]       wdata,
   output region_t [N-1:0]   regs
);

   for (genvar r = 0; r < N; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[r] <= '0;
         end else if (we && idx == IW'(r)) begin
            case (field_t'(field))
               FLD_CTRL: begin
                  regs[r].en   <= wdata[0];
                  regs[r].sp   <= space_t'(wdata[2:1]);
                  regs[r].wide <= wdata[3];
               end
               FLD_BASE_LO: regs[r].base   <= put_word(regs[r].base,   1'b0, wdata);
               FLD_BASE_HI: regs[r].base   <= put_word(regs[r].base,   1'b1, wdata);
               FLD_LIM_LO:  regs[r].limit  <= put_word(regs[r].limit,  1'b0, wdata);
               FLD_LIM_HI:  regs[r].limit  <= put_word(regs[r].limit,  1'b1, wdata);
               FLD_TGT_LO:  regs[r].target <= put_word(regs[r].target, 1'b0, wdata);
               FLD_TGT_HI:  regs[r].target <= put_word(regs[r].target, 1'b1, wdata);
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/xlate_match.sv
module xlate_match
   import addr_xlate_pkg::*;
#(
   parameter  int unsigned N        = 4,
   parameter  int unsigned IN_W     = 28,
   parameter  int unsigned OUT_W    = 64,
   parameter  bit          LOW_WINS = 1'b1,
   localparam int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
   input  space_t           req_sp,
   input  logic [IN_W-1:0]  req_addr,
   input  region_t [N-1:0]  regs,
   output logic             hit,
   output logic [IW-1:0]    idx,
   output logic             wide,
   output logic [OUT_W-1:0] addr
);

   logic [N-1:0] hit_v;
   region_t      sel;

   for (genvar r = 0; r < N; r++) begin : g_cmp
      assign hit_v[r] = regs[r].en && (regs[r].sp == req_sp) &&
                        (req_addr >= regs[r].base[IN_W-1:0]) &&
                        (req_addr <= regs[r].limit[IN_W-1:0]);
   end

   if (LOW_WINS) begin : g_low
      always_comb begin
         idx = '0;
         for (int r = N - 1; r >= 0; r--)
            if (hit_v[r]) idx = IW'(r);
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int r = 0; r < N; r++)
            if (hit_v[r]) idx = IW'(r);
      end
   end

   assign hit = |hit_v;
   assign sel = regs[idx];

   always_comb begin
      addr = '0;
      wide = 1'b0;
      if (hit) begin
         addr = sel.target[OUT_W-1:0] + OUT_W'(req_addr - sel.base[IN_W-1:0]);
         wide = sel.wide;
      end
   end

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
   import addr_xlate_pkg::*;
#(
   parameter  int unsigned OB_N  = 4,
   parameter  int unsigned IB_N  = 4,
   parameter  int unsigned WIN_W = 28,
   parameter  int unsigned EXT_W = 64,
   parameter  int unsigned LOC_W = 32,
   parameter  int unsigned CFG_W = 28,
   localparam int unsigned OB_IW = (OB_N > 1) ? $clog2(OB_N) : 1,
   localparam int unsigned IB_IW = (IB_N > 1) ? $clog2(IB_N) : 1,
   localparam int unsigned R_IW  = (OB_IW > IB_IW) ? OB_IW : IB_IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_dir,
   input  logic [R_IW-1:0]  reg_idx,
   input  logic [2:0]       reg_field,
   input  logic [31:0]      reg_wdata,
   input  logic             ob_req_valid,
   input  logic [1:0]       ob_req_space,
   input  logic [WIN_W-1:0] ob_req_offset,
   output logic             ob_rsp_valid,
   output logic             ob_rsp_miss,
   output logic [OB_IW-1:0] ob_rsp_region,
   output logic [1:0]       ob_rsp_space,
   output logic [EXT_W-1:0] ob_rsp_addr,
   output logic [7:0]       ob_cfg_bus,
   output logic [4:0]       ob_cfg_dev,
   output logic [2:0]       ob_cfg_func,
   output logic [11:0]      ob_cfg_reg,
   input  logic             ib_req_valid,
   input  logic [1:0]       ib_req_space,
   input  logic [EXT_W-1:0] ib_req_addr,
   output logic             ib_rsp_valid,
   output logic             ib_rsp_miss,
   output logic             ib_rsp_cfg,
   output logic [IB_IW-1:0] ib_rsp_region,
   output logic [LOC_W-1:0] ib_rsp_addr
);

   initial begin
      assert (EXT_W > 32 && EXT_W <= REG_AW) else $error("EXT_W must lie in 33..64");
      assert (WIN_W > 2 && WIN_W <= EXT_W)   else $error("WIN_W out of range");
      assert (LOC_W > 2 && LOC_W <= EXT_W)   else $error("LOC_W out of range");
      assert (CFG_W == 28)                   else $error("config split needs CFG_W of 28");
      assert (OB_N > 0 && IB_N > 0)          else $error("region counts must be nonzero");
   end

   region_t [OB_N-1:0] ob_regs;
   region_t [IB_N-1:0] ib_regs;

   xlate_region_file #(.N(OB_N)) u_ob_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && !reg_dir),
      .idx   (reg_idx[OB_IW-1:0]),
      .field (reg_field),
      .wdata (reg_wdata),
      .regs  (ob_regs)
   );

   xlate_region_file #(.N(IB_N)) u_ib_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && reg_dir),
      .idx   (reg_idx[IB_IW-1:0]),
      .field (reg_field),
      .wdata (reg_wdata),
      .regs  (ib_regs)
   );

   // word alignment of both request paths
   logic [WIN_W-1:0] ob_off_al;
   logic [EXT_W-1:0] ib_addr_al;
   assign ob_off_al  = {ob_req_offset[WIN_W-1:2], 2'b00};
   assign ib_addr_al = {ib_req_addr[EXT_W-1:2], 2'b00};

   logic             ob_hit, ob_wide;
   logic [OB_IW-1:0] ob_idx;
   logic [EXT_W-1:0] ob_sum;

   xlate_match #(.N(OB_N), .IN_W(WIN_W), .OUT_W(EXT_W)) u_ob_match (
      .req_sp   (space_t'(ob_req_space)),
      .req_addr (ob_off_al),
      .regs     (ob_regs),
      .hit      (ob_hit),
      .idx      (ob_idx),
      .wide     (ob_wide),
      .addr     (ob_sum)
   );

   logic             ib_hit, ib_wide_unused;
   logic [IB_IW-1:0] ib_idx;
   logic [LOC_W-1:0] ib_sum;
   logic             ib_is_cfg;

   xlate_match #(.N(IB_N), .IN_W(EXT_W), .OUT_W(LOC_W)) u_ib_match (
      .req_sp   (space_t'(ib_req_space)),
      .req_addr (ib_addr_al),
      .regs     (ib_regs),
      .hit      (ib_hit),
      .idx      (ib_idx),
      .wide     (ib_wide_unused),
      .addr     (ib_sum)
   );

   assign ib_is_cfg = (space_t'(ib_req_space) == SP_CFG);

   // output width shaping by target space
   logic [EXT_W-1:0] ob_shaped;
   always_comb begin
      ob_shaped = '0;
      if (ob_hit) begin
         case (space_t'(ob_req_space))
            SP_MEM: ob_shaped = ob_wide ? ob_sum : EXT_W'(ob_sum[31:0]);
            SP_IO:  ob_shaped = EXT_W'(ob_sum[31:0]);
            SP_CFG: ob_shaped = EXT_W'(ob_sum[CFG_W-1:0]);
            default: ob_shaped = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ob_rsp_valid  <= 1'b0;
         ob_rsp_miss   <= 1'b0;
         ob_rsp_region <= '0;
         ob_rsp_space  <= '0;
         ob_rsp_addr   <= '0;
      end else begin
         ob_rsp_valid <= ob_req_valid;
         if (ob_req_valid) begin
            ob_rsp_miss   <= !ob_hit;
            ob_rsp_region <= ob_hit ? ob_idx : '0;
            ob_rsp_space  <= ob_req_space;
            ob_rsp_addr   <= ob_shaped;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ib_rsp_valid  <= 1'b0;
         ib_rsp_miss   <= 1'b0;
         ib_rsp_cfg    <= 1'b0;
         ib_rsp_region <= '0;
         ib_rsp_addr   <= '0;
      end else begin
         ib_rsp_valid <= ib_req_valid;
         if (ib_req_valid) begin
            ib_rsp_cfg    <= ib_is_cfg;
            ib_rsp_miss   <= !ib_is_cfg && !ib_hit;
            ib_rsp_region <= (!ib_is_cfg && ib_hit) ? ib_idx : '0;
            ib_rsp_addr   <= (!ib_is_cfg && ib_hit) ? ib_sum : '0;
         end
      end
   end

   logic cfg_live;
   assign cfg_live    = ob_rsp_valid && !ob_rsp_miss && (space_t'(ob_rsp_space) == SP_CFG);
   assign ob_cfg_bus  = cfg_live ? ob_rsp_addr[27:20] : '0;
   assign ob_cfg_dev  = cfg_live ? ob_rsp_addr[19:15] : '0;
   assign ob_cfg_func = cfg_live ? ob_rsp_addr[14:12] : '0;
   assign ob_cfg_reg  = cfg_live ? ob_rsp_addr[11:0]  : '0;

endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
   parameter int unsigned EXT_W = 64,
   parameter int unsigned LOC_W = 32,
   parameter int unsigned CFG_W = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ob_req_valid,
   input logic             ob_rsp_valid,
   input logic             ob_rsp_miss,
   input logic [1:0]       ob_rsp_space,
   input logic [EXT_W-1:0] ob_rsp_addr,
   input logic             ib_req_valid,
   input logic [1:0]       ib_req_space,
   input logic             ib_rsp_valid,
   input logic             ib_rsp_miss,
   input logic             ib_rsp_cfg,
   input logic [LOC_W-1:0] ib_rsp_addr
);

   // R2
   ob_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ob_req_valid |=> ob_rsp_valid);

   // R2
   ob_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ob_req_valid |=> !ob_rsp_valid);

   // R2
   ib_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ib_req_valid |=> ib_rsp_valid);

   // R5
   ob_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_rsp_valid && ob_rsp_miss) |-> (ob_rsp_addr == '0));

   // R5
   ib_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_rsp_valid && ib_rsp_miss) |-> (ib_rsp_addr == '0));

   // R6
   io_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_rsp_valid && ob_rsp_space == 2'd1) |-> (ob_rsp_addr[EXT_W-1:32] == '0));

   // R7
   cfg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_rsp_valid && ob_rsp_space == 2'd2) |-> (ob_rsp_addr[EXT_W-1:CFG_W] == '0));

   // R9
   ib_cfg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_req_valid && ib_req_space == 2'd2) |=>
         (ib_rsp_cfg && !ib_rsp_miss && ib_rsp_addr == '0));

endmodule

bind addr_xlate_unit addr_xlate_chk #(.EXT_W(EXT_W), .LOC_W(LOC_W), .CFG_W(CFG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ob_req_valid (ob_req_valid),
   .ob_rsp_valid (ob_rsp_valid),
   .ob_rsp_miss  (ob_rsp_miss),
   .ob_rsp_space (ob_rsp_space),
   .ob_rsp_addr  (ob_rsp_addr),
   .ib_req_valid (ib_req_valid),
   .ib_req_space (ib_req_space),
   .ib_rsp_valid (ib_rsp_valid),
   .ib_rsp_miss  (ib_rsp_miss),
   .ib_rsp_cfg   (ib_rsp_cfg),
   .ib_rsp_addr  (ib_rsp_addr)
);

// File: tb/test_addr_xlate_unit.sv
module test_addr_xlate_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_dir = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [2:0]  reg_field = '0;
   logic [31:0] reg_wdata = '0;
   logic        ob_req_valid = 1'b0;
   logic [1:0]  ob_req_space = '0;
   logic [27:0] ob_req_offset = '0;
   logic        ob_rsp_valid, ob_rsp_miss;
   logic [1:0]  ob_rsp_region, ob_rsp_space;
   logic [63:0] ob_rsp_addr;
   logic [7:0]  ob_cfg_bus;
   logic [4:0]  ob_cfg_dev;
   logic [2:0]  ob_cfg_func;
   logic [11:0] ob_cfg_reg;
   logic        ib_req_valid = 1'b0;
   logic [1:0]  ib_req_space = '0;
   logic [63:0] ib_req_addr = '0;
   logic        ib_rsp_valid, ib_rsp_miss, ib_rsp_cfg;
   logic [1:0]  ib_rsp_region;
   logic [31:0] ib_rsp_addr;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   addr_xlate_unit i_addr_xlate_unit (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic dir, input logic [1:0] idx, input logic [2:0] fld,
                     input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_dir = dir; reg_idx = idx; reg_field = fld; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // ctrl: bit0 enable, bits2:1 type, bit3 wide
   task automatic prog(input logic dir, input logic [1:0] idx, input logic [3:0] ctrl,
                       input logic [63:0] base, input logic [63:0] lim, input logic [63:0] tgt);
      wr(dir, idx, 3'd1, base[31:0]);
      wr(dir, idx, 3'd2, base[63:32]);
      wr(dir, idx, 3'd3, lim[31:0]);
      wr(dir, idx, 3'd4, lim[63:32]);
      wr(dir, idx, 3'd5, tgt[31:0]);
      wr(dir, idx, 3'd6, tgt[63:32]);
      wr(dir, idx, 3'd0, {28'd0, ctrl});
   endtask

   task automatic ob_look(input logic [1:0] sp, input logic [27:0] off);
      @(negedge clk);
      ob_req_valid = 1'b1; ob_req_space = sp; ob_req_offset = off;
      @(negedge clk);
      ob_req_valid = 1'b0;
   endtask

   task automatic ib_look(input logic [1:0] sp, input logic [63:0] a);
      @(negedge clk);
      ib_req_valid = 1'b1; ib_req_space = sp; ib_req_addr = a;
      @(negedge clk);
      ib_req_valid = 1'b0;
   endtask

   task automatic ob_expect(input string req, input logic miss, input logic [1:0] reg_n,
                            input logic [63:0] a);
      check({req, " valid"},  64'(ob_rsp_valid), 64'd1);
      check({req, " miss"},   64'(ob_rsp_miss), 64'(miss));
      if (!miss) check({req, " region"}, 64'(ob_rsp_region), 64'(reg_n));
      check({req, " addr"},   ob_rsp_addr, a);
   endtask

   task automatic ib_expect(input string req, input logic miss, input logic cfg,
                            input logic [1:0] reg_n, input logic [31:0] a);
      check({req, " valid"}, 64'(ib_rsp_valid), 64'd1);
      check({req, " miss"},  64'(ib_rsp_miss), 64'(miss));
      check({req, " cfg"},   64'(ib_rsp_cfg), 64'(cfg));
      if (!miss && !cfg) check({req, " region"}, 64'(ib_rsp_region), 64'(reg_n));
      check({req, " addr"},  64'(ib_rsp_addr), 64'(a));
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   task automatic t_reset;
      check("R1 ob valid after reset", 64'(ob_rsp_valid), 64'd0);
      check("R1 ib valid after reset", 64'(ib_rsp_valid), 64'd0);
      ob_look(2'd0, 28'h0000100);
      ob_expect("R1 unprogrammed outbound", 1'b1, 2'd0, 64'd0);
      ib_look(2'd0, 64'h100);
      ib_expect("R1 unprogrammed inbound", 1'b1, 1'b0, 2'd0, 32'd0);
   endtask

   task automatic t_program;
      // R11: program all region fields through the write port
      prog(1'b0, 2'd0, 4'b0001, 64'h0100000, 64'h01FFFFC, 64'h00000009_40000000);
      prog(1'b0, 2'd1, 4'b1001, 64'h0180000, 64'h02FFFFC, 64'h00000020_00000000);
      prog(1'b0, 2'd2, 4'b0011, 64'h0400000, 64'h040FFFC, 64'hFFFFFFFF_00001000);
      prog(1'b0, 2'd3, 4'b0101, 64'h0800000, 64'h0FFFFFC, 64'h0);
      prog(1'b1, 2'd0, 4'b0001, 64'h1_00000000, 64'h1_0000FFFC, 64'h80000000);
      prog(1'b1, 2'd1, 4'b0011, 64'h1000, 64'h1FFC, 64'h90000000);
      prog(1'b1, 2'd2, 4'b0101, 64'h0, 64'hFFFFFFFF_FFFFFFFC, 64'h1234);
   endtask

   task automatic t_ob_mem;
      ob_look(2'd0, 28'h0100000);
      ob_expect("R3 R6 base narrow", 1'b0, 2'd0, 64'h40000000);
      ob_look(2'd0, 28'h01FFFFC);
      ob_expect("R3 R4 limit inclusive", 1'b0, 2'd0, 64'h400FFFFC);
      ob_look(2'd0, 28'h0200000);
      ob_expect("R6 wide memory", 1'b0, 2'd1, 64'h00000020_00080000);
      ob_look(2'd0, 28'h0300000);
      ob_expect("R5 above limit", 1'b1, 2'd0, 64'd0);
      ob_look(2'd0, 28'h00FFFFC);
      ob_expect("R5 below base", 1'b1, 2'd0, 64'd0);
   endtask

   task automatic t_ob_io;
      ob_look(2'd1, 28'h0400010);
      ob_expect("R6 io upper zero", 1'b0, 2'd2, 64'h00001010);
      ob_look(2'd0, 28'h0400010);
      ob_expect("R5 type mismatch", 1'b1, 2'd0, 64'd0);
   endtask

   task automatic t_ob_cfg;
      ob_look(2'd2, 28'h0B2A1A4);
      ob_expect("R7 cfg addr", 1'b0, 2'd3, 64'h32A1A4);
      check("R7 bus",  64'(ob_cfg_bus),  64'd3);
      check("R7 dev",  64'(ob_cfg_dev),  64'd5);
      check("R7 func", 64'(ob_cfg_func), 64'd2);
      check("R7 reg",  64'(ob_cfg_reg),  64'h1A4);
      ob_look(2'd2, 28'h0B2A1A7);
      ob_expect("R10 low bits ignored", 1'b0, 2'd3, 64'h32A1A4);
      ob_look(2'd0, 28'h0100000);
      check("R7 fields zero on memory", 64'(ob_cfg_bus), 64'd0);
   endtask

   task automatic t_priority;
      ob_look(2'd0, 28'h0180000);
      ob_expect("R4 overlap lowest wins", 1'b0, 2'd0, 64'h40080000);
      wr(1'b0, 2'd0, 3'd0, 32'h0);   // R11 disable region 0
      ob_look(2'd0, 28'h0180000);
      ob_expect("R4 next region after disable", 1'b0, 2'd1, 64'h00000020_00000000);
      wr(1'b0, 2'd2, 3'd0, 32'h2);   // io type, enable clear
      ob_look(2'd1, 28'h0400010);
      ob_expect("R11 R5 disabled region misses", 1'b1, 2'd0, 64'd0);
   endtask

   task automatic t_inbound;
      ib_look(2'd0, 64'h1_00000100);
      ib_expect("R8 inbound memory", 1'b0, 1'b0, 2'd0, 32'h80000100);
      ib_look(2'd1, 64'h1802);
      ib_expect("R8 R10 inbound io", 1'b0, 1'b0, 2'd1, 32'h90000800);
      ib_look(2'd1, 64'h1_00000100);
      ib_expect("R5 inbound type mismatch", 1'b1, 1'b0, 2'd0, 32'd0);
      ib_look(2'd0, 64'h3_00000000);
      ib_expect("R5 inbound out of range", 1'b1, 1'b0, 2'd0, 32'd0);
      ib_look(2'd2, 64'h10);
      ib_expect("R9 config bypass", 1'b0, 1'b1, 2'd0, 32'd0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      ob_req_valid = 1'b1; ob_req_space = 2'd0; ob_req_offset = 28'h0200000;
      ib_req_valid = 1'b1; ib_req_space = 2'd0; ib_req_addr = 64'h1_00000004;
      check("R2 ob not valid same cycle", 64'(ob_rsp_valid), 64'd0);
      @(negedge clk);
      ob_req_valid = 1'b0; ib_req_valid = 1'b0;
      check("R2 ob valid next cycle", 64'(ob_rsp_valid), 64'd1);
      check("R2 ib valid next cycle", 64'(ib_rsp_valid), 64'd1);
      check("R2 ib parallel addr", 64'(ib_rsp_addr), 64'h80000004);
      @(negedge clk);
      check("R2 ob drops after one", 64'(ob_rsp_valid), 64'd0);
      check("R2 ib drops after one", 64'(ib_rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_ob_mem();
      t_ob_io();
      t_ob_cfg();
      t_priority();
      t_inbound();
      t_latency();
      finish_up();
   end

endmodule